// File: doc/BRIEF.md
# Complementary PWM Deadtime Inserter

This block sits after the compare-match logic of a timer running in complementary mode. For each channel pair it takes one reference bit and produces two outputs, the even channel (n) and the odd channel (n+1). The two outputs are never active together. When the reference changes, the output that is on goes to its idle level on the next clock. The output that is coming on waits for a programmable deadtime before it reaches its active level.

The deadtime is a count of prescaled system-clock ticks. One setting serves every pair: an enable bit, a 2-bit prescale code and a 6-bit modulo. Each output has its own polarity bit, which picks whether its idle level is low or high. Each pair has its own state machine with five states:

- `ST_SAFE` is the reset state, with both outputs idle.
- `ST_EVEN_ON` and `ST_ODD_ON` each drive one output active.
- `ST_DEAD_EVEN` and `ST_DEAD_ODD` hold both outputs idle while the deadtime runs toward the named side.

The transitions are:

- **SAFE→DEAD_x / SAFE→x_ON**: the first clock after reset, chosen by the reference and by whether deadtime is on.
- **x_ON→DEAD_y**: the reference flips while deadtime is on.
- **x_ON→y_ON**: the reference flips while deadtime is off.
- **DEAD_x→x_ON**: the count completes.
- **DEAD_x→DEAD_y**: the reference flips again during the count, so the count restarts.
- **DEAD_x→x_ON or y_ON**: deadtime is switched off during the count, so the outputs follow the reference directly.

Top module: `pwm_deadtime_top`

## Requirements
- R1: When `dt_enable` is 0 or `dt_modulo` is 0 (checked every clock), a change of `pwm_ref[i]` makes the newly selected output active one clock later, with no gap. `pwm_ref[i]`=1 selects the even output and 0 selects the odd output.
- R2: With deadtime on, the newly selected output becomes active exactly `dt_modulo` × D clocks after the first clock edge that sees the reference change. D is set by `dt_prescale`: codes 00 and 01 give 1, 10 gives 4, and 11 gives 16.
- R3: The even and odd outputs of a pair are never active in the same cycle.
- R4: An output whose polarity bit is 0 idles low and is high when active, so the delayed edge is a rising edge.
- R5: An output whose polarity bit is 1 idles high and is low when active, so the delayed edge is a falling edge.
- R6: The output being turned off reaches its idle level on the first clock after the reference change, without waiting for the deadtime.
- R7: If the reference changes again before the count ends, the pending delay is dropped. Both outputs stay idle until a full deadtime has passed from the latest change.
- R8: While `rst_n` is low, each output sits at its idle level (equal to its polarity bit) and the deadtime counters are cleared.
- R9: A prescale code or nonzero modulo written during a running interval does not alter that interval. It applies from the next reference change.
- R10: One deadtime setting drives every pair, and each pair sequences independently from its own reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dt_enable | input | 1 | Deadtime enable, shared by all pairs |
| dt_prescale | input | 2 | Prescale code: 00/01 divide by 1, 10 by 4, 11 by 16 |
| dt_modulo | input | 6 | Deadtime length in prescaled ticks; 0 disables the delay |
| pol_even | input | NUM_PAIRS | Polarity per even output; 1 = idle high |
| pol_odd | input | NUM_PAIRS | Polarity per odd output; 1 = idle high |
| pwm_ref | input | NUM_PAIRS | Complementary reference per pair; 1 selects the even side |
| out_even | output | NUM_PAIRS | Channel n output per pair |
| out_odd | output | NUM_PAIRS | Channel n+1 output per pair |

## Verification
The assertions assume that `pwm_ref`, the deadtime settings and the polarity bits are synchronous to `clk`, and that polarity stays fixed while a pair is running. They define an output's active state as the output level XORed with its polarity, so a polarity change in mid-run would look like a spurious edge. The stimulus writes polarity only while reset is held. It changes all other inputs half a period away from the active edge, and changes prescale and modulo only to nonzero values once deadtime is running, so the enable condition seen by the assertions matches the one the design uses.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;

    localparam int DIV_W = 4;

    typedef enum logic [2:0] {
        ST_SAFE      = 3'd0,
        ST_EVEN_ON   = 3'd1,
        ST_ODD_ON    = 3'd2,
        ST_DEAD_EVEN = 3'd3,
        ST_DEAD_ODD  = 3'd4
    } dt_state_e;

    // reload value of the prescale counter (divider minus one)
    function automatic logic [DIV_W-1:0] div_reload(input logic [1:0] code);
        logic [DIV_W-1:0] r;
        unique case (code)
            2'b10:   r = 4'd3;
            2'b11:   r = 4'd15;
            default: r = 4'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dt_cfg.sv
module dt_cfg
    import pwm_dt_pkg::*;
#(
    parameter int MOD_W = 6
) (
    input  logic             enable,
    input  logic [1:0]       prescale,
    input  logic [MOD_W-1:0] modulo,
    output logic             dt_on,
    output logic [DIV_W-1:0] reload
);

    always_comb begin
        dt_on  = enable && (modulo != '0);
        reload = div_reload(prescale);
    end

endmodule

// File: rtl/dt_timer.sv
module dt_timer
    import pwm_dt_pkg::*;
#(
    parameter int MOD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] reload_in,
    input  logic [MOD_W-1:0] ticks_in,
    output logic             done
);

    logic [DIV_W-1:0] pre_cnt;
    logic [DIV_W-1:0] reload_q;
    logic [MOD_W-1:0] remain;

    // settings are captured only on load, so mid-interval writes wait
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            reload_q <= '0;
            remain   <= '0;
        end else if (load) begin
            pre_cnt  <= reload_in;
            reload_q <= reload_in;
            remain   <= ticks_in;
        end else if (run) begin
            if (pre_cnt == '0) begin
                pre_cnt <= reload_q;
                remain  <= remain - 1'b1;
            end else begin
                pre_cnt <= pre_cnt - 1'b1;
            end
        end
    end

    always_comb begin
        done = run && !load && (pre_cnt == '0) && (remain == MOD_W'(1));
    end

endmodule

// File: rtl/dt_pair_fsm.sv
module dt_pair_fsm
    import pwm_dt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic dt_on,
    input  logic done,
    input  logic pol_e,
    input  logic pol_o,
    output logic load,
    output logic run,
    output logic out_e,
    output logic out_o
);

    dt_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SAFE;
        else        state <= nxt;
    end

    always_comb begin
        nxt  = state;
        load = 1'b0;
        unique case (state)
            ST_SAFE: begin
                if (dt_on) begin
                    nxt  = ref_in ? ST_DEAD_EVEN : ST_DEAD_ODD;
                    load = 1'b1;
                end else begin
                    nxt = ref_in ? ST_EVEN_ON : ST_ODD_ON;
                end
            end
            ST_EVEN_ON: begin
                if (!ref_in) begin
                    if (dt_on) begin
                        nxt  = ST_DEAD_ODD;
                        load = 1'b1;
                    end else begin
                        nxt = ST_ODD_ON;
                    end
                end
            end
            ST_ODD_ON: begin
                if (ref_in) begin
                    if (dt_on) begin
                        nxt  = ST_DEAD_EVEN;
                        load = 1'b1;
                    end else begin
                        nxt = ST_EVEN_ON;
                    end
                end
            end
            ST_DEAD_EVEN: begin
                if (!dt_on) begin
                    nxt = ref_in ? ST_EVEN_ON : ST_ODD_ON;
                end else if (!ref_in) begin
                    nxt  = ST_DEAD_ODD;
                    load = 1'b1;
                end else if (done) begin
                    nxt = ST_EVEN_ON;
                end
            end
            ST_DEAD_ODD: begin
                if (!dt_on) begin
                    nxt = ref_in ? ST_EVEN_ON : ST_ODD_ON;
                end else if (ref_in) begin
                    nxt  = ST_DEAD_EVEN;
                    load = 1'b1;
                end else if (done) begin
                    nxt = ST_ODD_ON;
                end
            end
            default: nxt = ST_SAFE;
        endcase
    end

    always_comb begin
        run   = (state == ST_DEAD_EVEN) || (state == ST_DEAD_ODD);
        out_e = pol_e ^ (state == ST_EVEN_ON);
        out_o = pol_o ^ (state == ST_ODD_ON);
    end

endmodule

// File: rtl/pwm_deadtime_top.sv
module pwm_deadtime_top
    import pwm_dt_pkg::*;
#(
    parameter int NUM_PAIRS = 2,
    parameter int MOD_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dt_enable,
    input  logic [1:0]           dt_prescale,
    input  logic [MOD_W-1:0]     dt_modulo,
    input  logic [NUM_PAIRS-1:0] pol_even,
    input  logic [NUM_PAIRS-1:0] pol_odd,
    input  logic [NUM_PAIRS-1:0] pwm_ref,
    output logic [NUM_PAIRS-1:0] out_even,
    output logic [NUM_PAIRS-1:0] out_odd
);

    logic             dt_on;
    logic [DIV_W-1:0] reload;

    // R10: single shared setting
    dt_cfg #(.MOD_W(MOD_W)) u_cfg (
        .enable   (dt_enable),
        .prescale (dt_prescale),
        .modulo   (dt_modulo),
        .dt_on    (dt_on),
        .reload   (reload)
    );

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        logic load, run, done;

        dt_timer #(.MOD_W(MOD_W)) u_timer (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load),
            .run       (run),
            .reload_in (reload),
            .ticks_in  (dt_modulo),
            .done      (done)
        );

        dt_pair_fsm u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .ref_in (pwm_ref[i]),
            .dt_on  (dt_on),
            .done   (done),
            .pol_e  (pol_even[i]),
            .pol_o  (pol_odd[i]),
            .load   (load),
            .run    (run),
            .out_e  (out_even[i]),
            .out_o  (out_odd[i])
        );
    end

endmodule

// File: rtl/pwm_deadtime_chk.sv
module pwm_deadtime_chk #(
    parameter int NUM_PAIRS = 2,
    parameter int MOD_W     = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dt_enable,
    input logic [1:0]           dt_prescale,
    input logic [MOD_W-1:0]     dt_modulo,
    input logic [NUM_PAIRS-1:0] pol_even,
    input logic [NUM_PAIRS-1:0] pol_odd,
    input logic [NUM_PAIRS-1:0] pwm_ref,
    input logic [NUM_PAIRS-1:0] out_even,
    input logic [NUM_PAIRS-1:0] out_odd
);

    logic                 gap_mode;
    logic [NUM_PAIRS-1:0] e_act, o_act;

    always_comb begin
        gap_mode = dt_enable && (dt_modulo != '0);
        e_act    = out_even ^ pol_even;
        o_act    = out_odd ^ pol_odd;
    end

    // R8
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (out_even == pol_even) && (out_odd == pol_odd));

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_chk
        // R3
        no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(e_act[i] && o_act[i]));

        // R6
        even_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (e_act[i] && !pwm_ref[i]) |=> !e_act[i]);

        // R6
        odd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (o_act[i] && pwm_ref[i]) |=> !o_act[i]);

        // R1
        direct_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!gap_mode && pwm_ref[i]) |=> e_act[i]);

        // R1
        direct_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!gap_mode && !pwm_ref[i]) |=> o_act[i]);

        // R2
        even_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gap_mode && $past(gap_mode) && $rose(e_act[i])) |-> $past(!o_act[i] && !e_act[i]));

        // R2
        odd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gap_mode && $past(gap_mode) && $rose(o_act[i])) |-> $past(!o_act[i] && !e_act[i]));
    end

endmodule

bind pwm_deadtime_top pwm_deadtime_chk #(
    .NUM_PAIRS (NUM_PAIRS),
    .MOD_W     (MOD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dt_enable   (dt_enable),
    .dt_prescale (dt_prescale),
    .dt_modulo   (dt_modulo),
    .pol_even    (pol_even),
    .pol_odd     (pol_odd),
    .pwm_ref     (pwm_ref),
    .out_even    (out_even),
    .out_odd     (out_odd)
);

// File: tb/pwm_deadtime_top_bench.sv
module pwm_deadtime_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dt_enable = 1'b0;
    logic [1:0] dt_prescale = 2'b00;
    logic [5:0] dt_modulo = 6'd0;
    logic [1:0] pol_even = 2'b00;
    logic [1:0] pol_odd = 2'b00;
    logic [1:0] pwm_ref = 2'b11;
    logic [1:0] out_even, out_odd;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pwm_deadtime_top u_pwm_deadtime_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .dt_enable   (dt_enable),
        .dt_prescale (dt_prescale),
        .dt_modulo   (dt_modulo),
        .pol_even    (pol_even),
        .pol_odd     (pol_odd),
        .pwm_ref     (pwm_ref),
        .out_even    (out_even),
        .out_odd     (out_odd)
    );

    function automatic bit act_e(int p);
        return out_even[p] ^ pol_even[p];
    endfunction

    function automatic bit act_o(int p);
        return out_odd[p] ^ pol_odd[p];
    endfunction

    task automatic check(string req, string what, int actual, int expected);
        n_cmp++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    task automatic do_reset(input bit r0, input bit r1);
        rst_n = 1'b0;
        pwm_ref = {r1, r0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (1100) @(negedge clk);
    endtask

    task automatic flip(input int p, input bit v);
        @(negedge clk);
        pwm_ref[p] = v;
    endtask

    // counts clocks from the first edge after a flip until the new side is active
    task automatic measure(input int p, input bit to_even, input int chg_at,
                           input logic [5:0] nm, input logic [1:0] nc,
                           output int cyc, output bit old_off, output bit overlap);
        cyc = -1; old_off = 0; overlap = 0;
        for (int k = 1; k <= 1200; k++) begin
            @(negedge clk);
            if (act_e(p) && act_o(p)) overlap = 1;
            if (k == 1) old_off = to_even ? !act_o(p) : !act_e(p);
            if (k == chg_at) begin
                dt_modulo = nm;
                dt_prescale = nc;
            end
            if (to_even ? act_e(p) : act_o(p)) begin
                cyc = k - 1;
                break;
            end
        end
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        pol_even = 2'b01;
        pol_odd = 2'b10;
        repeat (2) @(negedge clk);
        check("R8", "out_even idle in reset", int'(out_even), 1);
        check("R8", "out_odd idle in reset", int'(out_odd), 2);
        pol_even = 2'b00;
        pol_odd = 2'b00;
        @(negedge clk);
        check("R4", "even idles low with pol 0", int'(out_even[0]), 0);
        check("R4", "odd idles low with pol 0", int'(out_odd[1]), 0);
    endtask

    task automatic t_no_delay();
        int c; bit off, ov;
        dt_enable = 1'b0; dt_modulo = 6'd20; dt_prescale = 2'b00;
        do_reset(1'b1, 1'b1);
        flip(0, 1'b0);
        measure(0, 1'b0, 0, 6'd0, 2'b00, c, off, ov);
        check("R1", "enable off: odd delay", c, 0);
        check("R6", "enable off: even released", int'(off), 1);
        dt_enable = 1'b1; dt_modulo = 6'd0;
        flip(0, 1'b1);
        measure(0, 1'b1, 0, 6'd0, 2'b00, c, off, ov);
        check("R1", "modulo zero: even delay", c, 0);
        check("R3", "modulo zero: no overlap", int'(ov), 0);
    endtask

    task automatic t_divider();
        int c; bit off, ov;
        int div_tab[4] = '{1, 1, 4, 16};
        dt_enable = 1'b1; dt_modulo = 6'd5; dt_prescale = 2'b00;
        do_reset(1'b1, 1'b1);
        for (int code = 0; code < 4; code++) begin
            dt_prescale = 2'(code);
            flip(0, 1'b0);
            measure(0, 1'b0, 0, 6'd0, 2'b00, c, off, ov);
            check("R2", $sformatf("code %0d to odd", code), c, 5 * div_tab[code]);
            check("R6", $sformatf("code %0d even off next clock", code), int'(off), 1);
            check("R3", $sformatf("code %0d overlap", code), int'(ov), 0);
            check("R4", "odd active high with pol 0", int'(out_odd[0]), 1);
            flip(0, 1'b1);
            measure(0, 1'b1, 0, 6'd0, 2'b00, c, off, ov);
        end
    endtask

    task automatic t_pol_high();
        int c; bit off, ov;
        rst_n = 1'b0;
        pol_even = 2'b11; pol_odd = 2'b11;
        dt_enable = 1'b1; dt_modulo = 6'd7; dt_prescale = 2'b10;
        do_reset(1'b1, 1'b1);
        check("R5", "even active low", int'(out_even[0]), 0);
        flip(0, 1'b0);
        @(negedge clk);
        check("R5", "both idle high in gap", int'({out_even[0], out_odd[0]}), 3);
        measure(0, 1'b0, 0, 6'd0, 2'b00, c, off, ov);
        check("R2", "pol 1 delay", c + 1, 28);
        check("R5", "odd driven low after gap", int'(out_odd[0]), 0);
        rst_n = 1'b0;
        pol_even = 2'b00; pol_odd = 2'b00;
    endtask

    task automatic t_abort();
        int c; bit off, ov;
        bit odd_seen = 0;
        dt_enable = 1'b1; dt_modulo = 6'd12; dt_prescale = 2'b00;
        do_reset(1'b1, 1'b1);
        flip(0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (act_o(0) || act_e(0)) odd_seen = 1;
        end
        check("R7", "both idle before retoggle", int'(odd_seen), 0);
        pwm_ref[0] = 1'b1;
        measure(0, 1'b1, 0, 6'd0, 2'b00, c, off, ov);
        check("R7", "full deadtime from latest edge", c, 12);
        check("R7", "no overlap on abort", int'(ov), 0);
    endtask

    task automatic t_sample();
        int c; bit off, ov;
        dt_enable = 1'b1; dt_modulo = 6'd10; dt_prescale = 2'b00;
        do_reset(1'b1, 1'b1);
        flip(0, 1'b0);
        measure(0, 1'b0, 2, 6'd3, 2'b11, c, off, ov);
        check("R9", "running interval unchanged", c, 10);
        flip(0, 1'b1);
        measure(0, 1'b1, 0, 6'd0, 2'b00, c, off, ov);
        check("R9", "next interval uses new setting", c, 48);
    endtask

    task automatic t_pairs();
        int c0 = -1;
        int c1 = -1;
        bit ov = 0;
        dt_enable = 1'b1; dt_modulo = 6'd6; dt_prescale = 2'b10;
        do_reset(1'b1, 1'b0);
        @(negedge clk);
        pwm_ref = 2'b10;
        for (int k = 1; k <= 200; k++) begin
            @(negedge clk);
            if ((act_e(0) && act_o(0)) || (act_e(1) && act_o(1))) ov = 1;
            if (c0 < 0 && act_o(0)) c0 = k - 1;
            if (c1 < 0 && act_e(1)) c1 = k - 1;
        end
        check("R10", "pair 0 delay", c0, 24);
        check("R10", "pair 1 delay", c1, 24);
        check("R3", "no overlap in either pair", int'(ov), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_no_delay();
        t_divider();
        t_pol_high();
        t_abort();
        t_sample();
        t_pairs();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule